// File: doc/BRIEF.md
# Modulo-3 Residue Check Unit

This block protects an arithmetic element with 2-bit modulo-3 residue codes. Each data unit carries two independent codes: one for its 36-bit mantissa magnitude and one for its 10-bit exponent field. The unit does three things. It produces the codes for a freshly computed result. It checks that the codes arriving with both operands match the operand values. It predicts the residue of the result from the operand codes and the operation, then compares that prediction with a residue computed directly from the result bits.

Each field is checked with its own operation code, because the exponent and mantissa paths do different things. For example, a multiply adds the exponents and multiplies the mantissas. Any disagreement in a checked cycle sets a sticky error flag for the affected field and raises an interrupt request. It also produces a one-cycle write-inhibit pulse, so that memory control can drop the pending store. An acknowledge input clears the sticky flags.

Residue coding cannot see an error whose size is a multiple of three. Such corruptions pass unflagged by design.

Top module: `mod3_residue_chk`

## Requirements
- R1: `gen_man_res` always equals `rslt_man` modulo 3, combinationally, encoded as 2'b00, 2'b01 or 2'b10.
- R2: `gen_exp_res` always equals `rslt_exp` modulo 3, combinationally, with the same encoding as R1.
- R3: In a cycle with `chk_valid` high, the result prediction uses the operation code: 2'b00 adds the two operand residues, 2'b01 subtracts them (first minus second), and 2'b10 multiplies them, all modulo 3. Code 2'b11 skips the prediction. If the prediction differs from the result residue, the matching field flag is high after the next rising clock edge.
- R4: The mantissa and exponent fields are checked independently. A failure in one field sets only that field's flag (`err_man` or `err_exp`).
- R5: In a checked cycle, an operand residue that differs from its operand value modulo 3 flags its field. This holds even when the operation code is 2'b11.
- R6: An operand residue of 2'b11 is an illegal code and flags its field on its own.
- R7: A result corrupted by an amount that is a multiple of 3, with correct operand codes, raises no flag.
- R8: A field flag stays high until `err_ack` is sampled high at a clock edge, which clears it. If a new failure of that field occurs in the same cycle as the acknowledge, the flag stays set.
- R9: `err_irq` is high exactly when `err_man` or `err_exp` is high.
- R10: `wr_inhibit` is high for exactly the one cycle after a checked cycle in which either field failed, and low otherwise.
- R11: While `chk_valid` is low, no input changes `err_man` or `err_exp`, apart from `err_ack` clearing them.
- R12: While `rst_n` is low, and right after it is released, `err_man`, `err_exp`, `err_irq` and `wr_inhibit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_valid | input | 1 | Operands and result are present and must be checked this cycle |
| man_op | input | 2 | Mantissa operation: 00 add, 01 subtract, 10 multiply, 11 no prediction |
| exp_op | input | 2 | Exponent operation, same encoding as man_op |
| opa_man | input | 36 | First operand mantissa magnitude |
| opa_man_res | input | 2 | Residue code carried with opa_man |
| opb_man | input | 36 | Second operand mantissa magnitude |
| opb_man_res | input | 2 | Residue code carried with opb_man |
| opa_exp | input | 10 | First operand exponent field |
| opa_exp_res | input | 2 | Residue code carried with opa_exp |
| opb_exp | input | 10 | Second operand exponent field |
| opb_exp_res | input | 2 | Residue code carried with opb_exp |
| rslt_man | input | 36 | Result mantissa magnitude |
| rslt_exp | input | 10 | Result exponent field |
| err_ack | input | 1 | Clears the sticky field flags |
| gen_man_res | output | 2 | Generated residue code of rslt_man |
| gen_exp_res | output | 2 | Generated residue code of rslt_exp |
| err_man | output | 1 | Sticky mantissa check failure |
| err_exp | output | 1 | Sticky exponent check failure |
| err_irq | output | 1 | Interrupt request, high while any field flag is set |
| wr_inhibit | output | 1 | One-cycle pulse that blocks the pending memory write |

## Verification
The assertions assume that the operand and result fields are fully driven during every cycle in which `chk_valid` is high. They also assume that `err_ack` is a known level at every edge after reset.

The random stimulus keeps each result genuinely consistent with its operation, so that a vector marked clean is really clean. Add operands are two bits narrower than the field, subtract operands are swapped so that the result is never negative, and multiply operands are half the field width. Because of these limits no result wraps, and the "+3" corruption still fits within the field.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_MUL  = 2'b10,
        OP_NONE = 2'b11
    } rop_e;

    localparam logic [1:0] RES_ILLEGAL = 2'b11;

    typedef struct packed {
        logic man_err;
        logic exp_err;
        logic irq;
        logic wr_blk;
    } flag_s;

    // modulo-3 sum of two residues in 0..2
    function automatic logic [1:0] add3(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) begin
            s = s - 3'd3;
        end
        return s[1:0];
    endfunction

    // additive inverse modulo 3
    function automatic logic [1:0] neg3(input logic [1:0] a);
        logic [1:0] r;
        case (a)
            2'd1:    r = 2'd2;
            2'd2:    r = 2'd1;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

    // modulo-3 product of two residues in 0..2
    function automatic logic [1:0] mul3(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] r;
        if (a == 2'd0 || b == 2'd0) begin
            r = 2'd0;
        end else if (a == 2'd1) begin
            r = b;
        end else if (b == 2'd1) begin
            r = a;
        end else begin
            r = 2'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mod3_reduce.sv
module mod3_reduce
    import mod3_pkg::*;
#(
    parameter int W = 36
) (
    input  logic [W-1:0] din,
    output logic [1:0]   res
);
    // bit i weighs 2^i, which is 1 or 2 mod 3 by parity; a bit pair weighs 4^k == 1
    localparam int NP  = (W + 1) / 2;
    localparam int WP  = 2 * NP;
    localparam int LVL = (NP > 1) ? $clog2(NP) : 0;
    localparam int NL  = 1 << LVL;

    logic [WP-1:0] padded;
    logic [1:0]    node [1:2*NL-1];

    assign padded = WP'(din);

    genvar gi;
    generate
        for (gi = 0; gi < NL; gi++) begin : g_leaf
            if (gi < NP) begin : g_used
                // pair value 0..3 folded to 0..2
                assign node[NL+gi] = (padded[2*gi+1 -: 2] == 2'b11) ? 2'b00
                                                                   : padded[2*gi+1 -: 2];
            end else begin : g_pad
                assign node[NL+gi] = 2'b00;
            end
        end
        for (gi = 1; gi < NL; gi++) begin : g_tree
            assign node[gi] = add3(node[2*gi], node[2*gi+1]);
        end
    endgenerate

    assign res = node[1];

endmodule

// File: rtl/mod3_predict.sv
module mod3_predict
    import mod3_pkg::*;
(
    input  logic [1:0] op,
    input  logic [1:0] ra,
    input  logic [1:0] rb,
    output logic [1:0] pred
);
    always_comb begin
        case (rop_e'(op))
            OP_ADD:  pred = add3(ra, rb);
            OP_SUB:  pred = add3(ra, neg3(rb));
            OP_MUL:  pred = mul3(ra, rb);
            default: pred = 2'b00;
        endcase
    end
endmodule

// File: rtl/mod3_field_chk.sv
module mod3_field_chk
    import mod3_pkg::*;
#(
    parameter int W = 36
) (
    input  logic [W-1:0] opa,
    input  logic [1:0]   opa_res,
    input  logic [W-1:0] opb,
    input  logic [1:0]   opb_res,
    input  logic [W-1:0] rslt,
    input  logic [1:0]   op,
    output logic [1:0]   gen_res,
    output logic         fail
);
    localparam int NV = 3;   // operand a, operand b, result

    logic [W-1:0] vals [NV];
    logic [1:0]   dres [NV];
    logic [1:0]   pred;
    logic         bad_code;
    logic         bad_opnd;
    logic         bad_rslt;

    assign vals[0] = opa;
    assign vals[1] = opb;
    assign vals[2] = rslt;

    genvar gv;
    generate
        for (gv = 0; gv < NV; gv++) begin : g_red
            mod3_reduce #(.W(W)) u_red (
                .din (vals[gv]),
                .res (dres[gv])
            );
        end
    endgenerate

    mod3_predict u_pred (
        .op   (op),
        .ra   (opa_res),
        .rb   (opb_res),
        .pred (pred)
    );

    always_comb begin
        bad_code = (opa_res == RES_ILLEGAL) || (opb_res == RES_ILLEGAL);
        bad_opnd = (opa_res != dres[0]) || (opb_res != dres[1]);
        bad_rslt = (rop_e'(op) != OP_NONE) && (pred != dres[2]);
        fail     = bad_code || bad_opnd || bad_rslt;
    end

    assign gen_res = dres[2];

endmodule

// File: rtl/mod3_residue_chk.sv
module mod3_residue_chk
    import mod3_pkg::*;
#(
    parameter int MAN_W = 36,
    parameter int EXP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [1:0]       man_op,
    input  logic [1:0]       exp_op,
    input  logic [MAN_W-1:0] opa_man,
    input  logic [1:0]       opa_man_res,
    input  logic [MAN_W-1:0] opb_man,
    input  logic [1:0]       opb_man_res,
    input  logic [EXP_W-1:0] opa_exp,
    input  logic [1:0]       opa_exp_res,
    input  logic [EXP_W-1:0] opb_exp,
    input  logic [1:0]       opb_exp_res,
    input  logic [MAN_W-1:0] rslt_man,
    input  logic [EXP_W-1:0] rslt_exp,
    input  logic             err_ack,
    output logic [1:0]       gen_man_res,
    output logic [1:0]       gen_exp_res,
    output logic             err_man,
    output logic             err_exp,
    output logic             err_irq,
    output logic             wr_inhibit
);
    logic  man_fail;
    logic  exp_fail;
    flag_s st_d;
    flag_s st_q;

    mod3_field_chk #(.W(MAN_W)) u_man (
        .opa     (opa_man),
        .opa_res (opa_man_res),
        .opb     (opb_man),
        .opb_res (opb_man_res),
        .rslt    (rslt_man),
        .op      (man_op),
        .gen_res (gen_man_res),
        .fail    (man_fail)
    );

    mod3_field_chk #(.W(EXP_W)) u_exp (
        .opa     (opa_exp),
        .opa_res (opa_exp_res),
        .opb     (opb_exp),
        .opb_res (opb_exp_res),
        .rslt    (rslt_exp),
        .op      (exp_op),
        .gen_res (gen_exp_res),
        .fail    (exp_fail)
    );

    always_comb begin
        st_d = st_q;
        if (err_ack) begin
            st_d.man_err = 1'b0;
            st_d.exp_err = 1'b0;
        end
        // a new failure wins over a simultaneous acknowledge
        if (chk_valid && man_fail) begin
            st_d.man_err = 1'b1;
        end
        if (chk_valid && exp_fail) begin
            st_d.exp_err = 1'b1;
        end
        st_d.irq    = st_d.man_err || st_d.exp_err;
        st_d.wr_blk = chk_valid && (man_fail || exp_fail);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_man    = st_q.man_err;
    assign err_exp    = st_q.exp_err;
    assign err_irq    = st_q.irq;
    assign wr_inhibit = st_q.wr_blk;

endmodule

// File: rtl/mod3_residue_chk_sva.sv
module mod3_residue_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       chk_valid,
    input logic       err_ack,
    input logic [1:0] opa_man_res,
    input logic [1:0] opb_exp_res,
    input logic [1:0] gen_man_res,
    input logic [1:0] gen_exp_res,
    input logic       err_man,
    input logic       err_exp,
    input logic       err_irq,
    input logic       wr_inhibit
);
    a_r1_gen_man_legal: assert property (@(posedge clk) disable iff (!rst_n)
        gen_man_res != 2'b11);

    a_r2_gen_exp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        gen_exp_res != 2'b11);

    a_r6_illegal_man: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && (opa_man_res == 2'b11) |=> err_man);

    a_r6_illegal_exp: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && (opb_exp_res == 2'b11) |=> err_exp);

    a_r8_man_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_man && !err_ack |=> err_man);

    a_r8_exp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_exp && !err_ack |=> err_exp);

    a_r9_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (err_man || err_exp));

    a_r10_wr_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid == 1'b0 |=> !wr_inhibit);

    a_r10_wr_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> err_irq);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid && !err_ack |=> $stable(err_man) && $stable(err_exp));

endmodule

bind mod3_residue_chk mod3_residue_chk_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_valid   (chk_valid),
    .err_ack     (err_ack),
    .opa_man_res (opa_man_res),
    .opb_exp_res (opb_exp_res),
    .gen_man_res (gen_man_res),
    .gen_exp_res (gen_exp_res),
    .err_man     (err_man),
    .err_exp     (err_exp),
    .err_irq     (err_irq),
    .wr_inhibit  (wr_inhibit)
);

// File: tb/mod3_residue_chk_tb_top.sv
module mod3_residue_chk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 36;
    localparam int EW = 10;
    localparam int NRAND = 400;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chk_valid;
    logic [1:0]    man_op, exp_op;
    logic [MW-1:0] opa_man, opb_man, rslt_man;
    logic [1:0]    opa_man_res, opb_man_res;
    logic [EW-1:0] opa_exp, opb_exp, rslt_exp;
    logic [1:0]    opa_exp_res, opb_exp_res;
    logic          err_ack;
    logic [1:0]    gen_man_res, gen_exp_res;
    logic          err_man, err_exp, err_irq, wr_inhibit;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_man  = 0;
    bit m_exp  = 0;
    bit m_wr   = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod3_residue_chk dut_i (
        .clk (clk), .rst_n (rst_n), .chk_valid (chk_valid),
        .man_op (man_op), .exp_op (exp_op),
        .opa_man (opa_man), .opa_man_res (opa_man_res),
        .opb_man (opb_man), .opb_man_res (opb_man_res),
        .opa_exp (opa_exp), .opa_exp_res (opa_exp_res),
        .opb_exp (opb_exp), .opb_exp_res (opb_exp_res),
        .rslt_man (rslt_man), .rslt_exp (rslt_exp),
        .err_ack (err_ack),
        .gen_man_res (gen_man_res), .gen_exp_res (gen_exp_res),
        .err_man (err_man), .err_exp (err_exp),
        .err_irq (err_irq), .wr_inhibit (wr_inhibit)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pred3(input int op, input int ra, input int rb);
        case (op)
            0:       return (ra + rb) % 3;
            1:       return (ra + 3 - rb) % 3;
            2:       return (ra * rb) % 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit field_bad(input int op, input longint unsigned a, input int ra,
                                     input longint unsigned b, input int rb,
                                     input longint unsigned r);
        if (ra != int'(a % 3) || rb != int'(b % 3)) return 1'b1;
        if (op != 3 && pred3(op, ra, rb) != int'(r % 3)) return 1'b1;
        return 1'b0;
    endfunction

    // apply current inputs for one clock, then compare against the model
    task automatic step();
        bit fm, fe;
        #1;
        check("R1 gen_man_res", gen_man_res, longint'(rslt_man % 3));
        check("R2 gen_exp_res", gen_exp_res, longint'(rslt_exp % 3));
        fm = chk_valid && field_bad(man_op, opa_man, opa_man_res, opb_man, opb_man_res, rslt_man);
        fe = chk_valid && field_bad(exp_op, opa_exp, opa_exp_res, opb_exp, opb_exp_res, rslt_exp);
        m_man = fm || (m_man && !err_ack);
        m_exp = fe || (m_exp && !err_ack);
        m_wr  = fm || fe;
        @(posedge clk);
        @(negedge clk);
        check("R3/R5/R8 err_man", err_man, m_man);
        check("R4/R5/R8 err_exp", err_exp, m_exp);
        check("R9 err_irq", err_irq, m_man || m_exp);
        check("R10 wr_inhibit", wr_inhibit, m_wr);
    endtask

    function automatic longint unsigned rnd(input int bits);
        longint unsigned v;
        v = {$urandom, $urandom};
        return v & ((64'd1 << bits) - 1);
    endfunction

    // build a consistent operand/result set, then corrupt it by kind:
    // 0 clean, 1 bit flip in result, 2 result +3, 3 wrong operand code, 4 illegal code
    task automatic build(input int w, input int op, input int kind,
                         output longint unsigned a, output longint unsigned b,
                         output longint unsigned r, output int ra, output int rb);
        longint unsigned t;
        case (op)
            0: begin a = rnd(w-2); b = rnd(w-2); r = a + b; end
            1: begin a = rnd(w-1); b = rnd(w-1);
                     if (a < b) begin t = a; a = b; b = t; end
                     r = a - b; end
            2: begin a = rnd(w/2); b = rnd(w/2); r = a * b; end
            default: begin a = rnd(w); b = rnd(w); r = rnd(w); end
        endcase
        ra = int'(a % 3);
        rb = int'(b % 3);
        case (kind)
            1: r = r ^ (64'd1 << ($urandom % w));
            2: r = r + 3;
            3: if ($urandom % 2) ra = (ra + 1) % 3; else rb = (rb + 2) % 3;
            4: if ($urandom % 2) ra = 3; else rb = 3;
            default: ;
        endcase
    endtask

    task automatic idle_inputs();
        chk_valid = 0; err_ack = 0; man_op = 0; exp_op = 0;
        opa_man = 0; opb_man = 0; rslt_man = 0; opa_man_res = 0; opb_man_res = 0;
        opa_exp = 0; opb_exp = 0; rslt_exp = 0; opa_exp_res = 0; opb_exp_res = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        longint unsigned a, b, r;
        int ra, rb;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R12 reset err_man", err_man, 0);
        check("R12 reset err_exp", err_exp, 0);
        check("R12 reset err_irq", err_irq, 0);
        check("R12 reset wr_inhibit", wr_inhibit, 0);
        rst_n = 1;
        @(negedge clk);
        check("R12 post-reset err_irq", err_irq, 0);

        // all-ones mantissa (mod 3 == 0), clean add with zero
        chk_valid = 1; man_op = 0; exp_op = 3;
        opa_man = '1; opa_man_res = 0; opb_man = 0; opb_man_res = 0; rslt_man = '1;
        step();
        check("R1 all-ones residue", gen_man_res, 0);

        // R7: mantissa product off by 3 passes unflagged
        man_op = 2; opa_man = 36'd7; opa_man_res = 1; opb_man = 36'd5; opb_man_res = 2;
        rslt_man = 36'd38;
        step();
        check("R7 no flag on +3 error", err_man, 0);

        // R3: op none with wrong result is not flagged
        man_op = 3; rslt_man = 36'd1;
        step();
        check("R3 op none ignored", err_man, 0);

        // R6: illegal exponent code flags only exponent (R4)
        exp_op = 3; opb_exp_res = 2'b11;
        step();
        check("R6 illegal code", err_exp, 1);
        check("R4 independent man flag", err_man, 0);

        // R11: valid low with garbage keeps flags
        chk_valid = 0; opa_man_res = 2'b11; rslt_man = 36'd5; man_op = 0;
        step();
        check("R11 idle hold", err_exp, 1);
        check("R11 idle no man flag", err_man, 0);

        // R8: ack together with a new exponent failure keeps it set
        chk_valid = 1; err_ack = 1; opa_man_res = 0; opa_man = 0; opb_man = 0;
        opb_man_res = 0; rslt_man = 0; man_op = 0;
        step();
        check("R8 set wins over ack", err_exp, 1);

        // R8: plain ack clears
        chk_valid = 0; opb_exp_res = 0;
        step();
        check("R8 ack clears", err_exp, 0);
        err_ack = 0;

        for (int i = 0; i < NRAND; i++) begin
            int kind_m, kind_e;
            chk_valid = ($urandom % 8) != 0;
            err_ack   = ($urandom % 8) == 0;
            man_op    = 2'($urandom % 4);
            exp_op    = 2'($urandom % 4);
            kind_m    = ($urandom % 3 == 0) ? int'($urandom % 5) : 0;
            kind_e    = ($urandom % 3 == 0) ? int'($urandom % 5) : 0;
            build(MW, man_op, kind_m, a, b, r, ra, rb);
            opa_man = a[MW-1:0]; opb_man = b[MW-1:0]; rslt_man = r[MW-1:0];
            opa_man_res = 2'(ra); opb_man_res = 2'(rb);
            build(EW, exp_op, kind_e, a, b, r, ra, rb);
            opa_exp = a[EW-1:0]; opb_exp = b[EW-1:0]; rslt_exp = r[EW-1:0];
            opa_exp_res = 2'(ra); opb_exp_res = 2'(rb);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule